// File: doc/BRIEF.md
# Per-Core Debug Breakpoint Controller

This unit sits beside one processor core and watches the instructions it retires. When a break condition that software has armed comes true, it raises a debug interrupt request for one cycle and holds an in-debug flag until the handler returns. The conditions are single-step, one program-counter match, a masked 32-bit instruction compare with a two-bit register-write qualifier, a break on the Nth hit of the address or instruction condition, and asynchronous requests from sibling cores. The debug interrupt is meant to be the highest-priority interrupt of the core. The core's interrupt logic takes `dbg_irq` ahead of every other source.

Break conditions are rewritten only while the core is inside its debug handler, through a small select/data write port. The new conditions take effect when the handler leaves with the return strobe. The unit also gates the core's writes to shared memory. When a global protect switch is on, writes into the top 16 KB of the hub address space are blocked unless the core is in debug. This lets handler code use that region freely while user code cannot corrupt it.

The controller is a three-state machine:
- S_RUN: conditions are evaluated.
- S_ENTRY: the one cycle in which the request is raised.
- S_HANDLER: the core runs its debug code.

It has these transitions:
- T_BREAK: S_RUN to S_ENTRY when any armed condition fires.
- T_SETTLE: S_ENTRY to S_HANDLER, always taken after one cycle.
- T_RESUME: S_HANDLER to S_RUN on the return strobe.

Top module: `dbg_break_ctrl`

## Requirements
- R1: After reset `dbg_irq` and `in_dbg` are low. The mode register holds only the async-enable bit. The address, mask, compare and count registers are zero, so no break fires on a retire at address 0.
- R2: Mode bit 0 (single-step) raises `dbg_irq` on the first retire after the return from debug, in the cycle after that retire. Cycles with no retire do not break.
- R3: Mode bit 1 breaks on a retire whose program counter equals the address register (select code 1). A retire at any other address does not break.
- R4: Mode bit 2 breaks on a retire where the instruction agrees with the compare register (select 3) in every bit set in the mask register (select 2). The retire must also satisfy the write qualifier: when mode bit 5 is set, `ret_wr` must equal mode bit 6.
- R5: With mode bit 4 set, address and instruction hits break only on the Nth hit after the return, where N is the count register (select 4). An N of 0 or 1 breaks on the first hit.
- R6: With mode bit 3 set, a pulse on any `async_req` bit other than the core's own index breaks. The core's own bit is never honoured. With bit 3 clear, async pulses are ignored.
- R7: While `in_dbg` is high, no break condition or async request raises `dbg_irq`. A request that arrives during debug is not kept for later.
- R8: A write on the configuration port while `in_dbg` is low changes nothing.
- R9: `reti0` in S_HANDLER drops `in_dbg` in the next cycle. A `reti0` during S_ENTRY or S_RUN is ignored.
- R10: `dbg_irq` is a single-cycle pulse. `in_dbg` rises in the same cycle as the pulse.
- R11: `hub_we_out` follows `hub_we_in`, except that it is low when `prot_en` is high, `in_dbg` is low, and `hub_addr` lies in the top 16 KB of the hub space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_vld | input | 1 | An instruction retires this cycle |
| ret_pc | input | PC_W | Program counter of the retiring instruction |
| ret_insn | input | DATA_W | Instruction word of the retiring instruction |
| ret_wr | input | 1 | Retiring instruction writes a register |
| async_req | input | NCORE | Break requests from sibling cores, one bit per core |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 mode, 1 address, 2 mask, 3 compare, 4 count |
| cfg_data | input | DATA_W | Configuration write data |
| reti0 | input | 1 | Return-from-debug strobe |
| hub_we_in | input | 1 | Core's hub write enable |
| hub_addr | input | HUB_AW | Core's hub byte address |
| prot_en | input | 1 | Global protect switch for the top region |
| dbg_irq | output | 1 | Debug interrupt request pulse |
| in_dbg | output | 1 | Core is in its debug handler |
| hub_we_out | output | 1 | Gated hub write enable |

## Verification
The response to a triggering retire or async pulse appears exactly one cycle later. Both `dbg_irq` and `in_dbg` come from the registered state. A return strobe taken in S_HANDLER clears `in_dbg` one cycle later. A configuration write becomes visible only through the behaviour after the next return. The write gate is combinational, so it answers in the same cycle.

Inputs change on the falling edge and are held through one rising edge. Outputs are then read at the following falling edge, so every check looks at the cycle in which the result is due. The gate is checked after a short settle with no clock edge. Each negative case is followed directly by a check that the pulse did not appear in its due cycle.

// File: rtl/dbg_break_pkg.sv
package dbg_break_pkg;

    typedef enum logic [1:0] {
        S_RUN     = 2'd0,
        S_ENTRY   = 2'd1,
        S_HANDLER = 2'd2
    } dbg_state_e;

    // Mode word, bit 0 at the bottom
    typedef struct packed {
        logic wr_val;   // [6] required register-write value
        logic wr_msk;   // [5] qualify on register write
        logic cnt;      // [4] break on Nth hit
        logic asyn;     // [3] honour sibling requests
        logic insn;     // [2] instruction pattern match
        logic addr;     // [1] program-counter match
        logic step;     // [0] single step
    } dbg_mode_t;

    localparam int MODE_W = 7;

    localparam logic [2:0] SEL_MODE = 3'd0;
    localparam logic [2:0] SEL_ADDR = 3'd1;
    localparam logic [2:0] SEL_MASK = 3'd2;
    localparam logic [2:0] SEL_CMP  = 3'd3;
    localparam logic [2:0] SEL_CNT  = 3'd4;

endpackage

// File: rtl/dbg_cond_regs.sv
module dbg_cond_regs
    import dbg_break_pkg::*;
#(
    parameter int PC_W     = 20,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 16,
    parameter logic [6:0] RST_MODE = 7'b000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_data,
    output dbg_mode_t         mode_q,
    output logic [PC_W-1:0]   addr_q,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] cmp_q,
    output logic [CNT_W-1:0]  cnt_q
);

    logic take;
    assign take = wr_ok && cfg_we;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= dbg_mode_t'(RST_MODE);
            addr_q <= '0;
            mask_q <= '0;
            cmp_q  <= '0;
            cnt_q  <= '0;
        end else if (take) begin
            unique case (cfg_sel)
                SEL_MODE: mode_q <= dbg_mode_t'(cfg_data[MODE_W-1:0]);
                SEL_ADDR: addr_q <= cfg_data[PC_W-1:0];
                SEL_MASK: mask_q <= cfg_data;
                SEL_CMP:  cmp_q  <= cfg_data;
                SEL_CNT:  cnt_q  <= cfg_data[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/dbg_match.sv
module dbg_match
    import dbg_break_pkg::*;
#(
    parameter int PC_W    = 20,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int NCORE   = 8,
    parameter int CORE_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval,
    input  logic              arm_load,
    input  logic              ret_vld,
    input  logic [PC_W-1:0]   ret_pc,
    input  logic [DATA_W-1:0] ret_insn,
    input  logic              ret_wr,
    input  logic [NCORE-1:0]  async_req,
    input  dbg_mode_t         mode_q,
    input  logic [PC_W-1:0]   addr_q,
    input  logic [DATA_W-1:0] mask_q,
    input  logic [DATA_W-1:0] cmp_q,
    input  logic [CNT_W-1:0]  cnt_q,
    output logic              trigger
);

    logic [NCORE-1:0] peer_mask;
    logic [CNT_W-1:0] remain_q;
    logic step_hit, addr_hit, insn_hit, wr_ok, cond_hit, cond_fire, async_hit;

    // Only sibling cores may request a break on this core
    for (genvar gi = 0; gi < NCORE; gi++) begin : g_peer
        assign peer_mask[gi] = (gi != CORE_ID);
    end

    assign wr_ok     = !mode_q.wr_msk || (ret_wr == mode_q.wr_val);
    assign step_hit  = mode_q.step && ret_vld;
    assign addr_hit  = mode_q.addr && ret_vld && (ret_pc == addr_q);
    assign insn_hit  = mode_q.insn && ret_vld && wr_ok &&
                       (((ret_insn ^ cmp_q) & mask_q) == '0);
    assign cond_hit  = addr_hit || insn_hit;
    assign cond_fire = cond_hit && (!mode_q.cnt || (remain_q <= CNT_W'(1)));
    assign async_hit = mode_q.asyn && |(async_req & peer_mask);
    assign trigger   = eval && (step_hit || cond_fire || async_hit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (arm_load) begin
            remain_q <= cnt_q;
        end else if (eval && cond_hit && mode_q.cnt && (remain_q > CNT_W'(1))) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/dbg_fsm.sv
module dbg_fsm
    import dbg_break_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trigger,
    input  logic       reti0,
    output dbg_state_e state_q,
    output logic       dbg_irq,
    output logic       in_dbg,
    output logic       eval,
    output logic       reti_take
);

    dbg_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN:     if (trigger) state_d = S_ENTRY;     // T_BREAK
            S_ENTRY:   state_d = S_HANDLER;                // T_SETTLE
            S_HANDLER: if (reti0) state_d = S_RUN;         // T_RESUME
            default:   state_d = S_RUN;
        endcase
    end

    always_comb begin
        dbg_irq   = 1'b0;
        in_dbg    = 1'b0;
        eval      = 1'b0;
        reti_take = 1'b0;
        unique case (state_q)
            S_RUN:     eval = 1'b1;
            S_ENTRY:   begin dbg_irq = 1'b1; in_dbg = 1'b1; end
            S_HANDLER: begin in_dbg = 1'b1; reti_take = reti0; end
            default:   ;
        endcase
    end

endmodule

// File: rtl/dbg_hub_gate.sv
module dbg_hub_gate #(
    parameter int HUB_AW  = 20,
    parameter int PROT_KB = 16
) (
    input  logic              hub_we_in,
    input  logic [HUB_AW-1:0] hub_addr,
    input  logic              prot_en,
    input  logic              in_dbg,
    output logic              hub_we_out
);

    localparam int PROT_AW = $clog2(PROT_KB * 1024);

    logic in_top;
    assign in_top     = &hub_addr[HUB_AW-1:PROT_AW];
    assign hub_we_out = hub_we_in && !(prot_en && !in_dbg && in_top);

endmodule

// File: rtl/dbg_break_ctrl.sv
module dbg_break_ctrl
    import dbg_break_pkg::*;
#(
    parameter int PC_W     = 20,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 16,
    parameter int NCORE    = 8,
    parameter int CORE_ID  = 0,
    parameter int HUB_AW   = 20,
    parameter int PROT_KB  = 16,
    parameter logic [6:0] RST_MODE = 7'b000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_vld,
    input  logic [PC_W-1:0]   ret_pc,
    input  logic [DATA_W-1:0] ret_insn,
    input  logic              ret_wr,
    input  logic [NCORE-1:0]  async_req,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              reti0,
    input  logic              hub_we_in,
    input  logic [HUB_AW-1:0] hub_addr,
    input  logic              prot_en,
    output logic              dbg_irq,
    output logic              in_dbg,
    output logic              hub_we_out
);

    dbg_mode_t         mode_q;
    logic [PC_W-1:0]   addr_q;
    logic [DATA_W-1:0] mask_q, cmp_q;
    logic [CNT_W-1:0]  cnt_q;
    dbg_state_e        state_q;
    logic              trigger, eval, reti_take;

    dbg_cond_regs #(
        .PC_W(PC_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RST_MODE(RST_MODE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ok(in_dbg),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .mode_q(mode_q), .addr_q(addr_q), .mask_q(mask_q),
        .cmp_q(cmp_q), .cnt_q(cnt_q)
    );

    dbg_match #(
        .PC_W(PC_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .NCORE(NCORE), .CORE_ID(CORE_ID)
    ) u_match (
        .clk(clk), .rst_n(rst_n), .eval(eval), .arm_load(reti_take),
        .ret_vld(ret_vld), .ret_pc(ret_pc), .ret_insn(ret_insn),
        .ret_wr(ret_wr), .async_req(async_req),
        .mode_q(mode_q), .addr_q(addr_q), .mask_q(mask_q),
        .cmp_q(cmp_q), .cnt_q(cnt_q), .trigger(trigger)
    );

    dbg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .trigger(trigger), .reti0(reti0),
        .state_q(state_q), .dbg_irq(dbg_irq), .in_dbg(in_dbg),
        .eval(eval), .reti_take(reti_take)
    );

    dbg_hub_gate #(
        .HUB_AW(HUB_AW), .PROT_KB(PROT_KB)
    ) u_gate (
        .hub_we_in(hub_we_in), .hub_addr(hub_addr), .prot_en(prot_en),
        .in_dbg(in_dbg), .hub_we_out(hub_we_out)
    );

endmodule

// File: rtl/dbg_break_chk.sv
module dbg_break_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dbg_irq,
    input logic       in_dbg,
    input logic       reti0,
    input logic       hub_we_in,
    input logic       hub_we_out,
    input logic [6:0] mode_q
);

    // R10: the request lasts one cycle
    a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_irq |=> !dbg_irq);

    // R10: the request comes with the in-debug flag
    a_r10_irq_in_dbg: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_irq |-> in_dbg);

    // R10: entering debug always goes through a request
    a_r10_rose_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_dbg) |-> dbg_irq);

    // R7: no new request while in debug
    a_r7_no_irq_in_dbg: assert property (@(posedge clk) disable iff (!rst_n)
        in_dbg |=> !dbg_irq);

    // R9: a return taken in the handler leaves debug
    a_r9_reti_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dbg && !dbg_irq && reti0) |=> !in_dbg);

    // R8: mode cannot change from outside debug
    a_r8_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !in_dbg |=> $stable(mode_q));

    // R11: debug code bypasses the protection
    a_r11_dbg_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        in_dbg |-> (hub_we_out == hub_we_in));

endmodule

bind dbg_break_ctrl dbg_break_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dbg_irq(dbg_irq), .in_dbg(in_dbg),
    .reti0(reti0), .hub_we_in(hub_we_in), .hub_we_out(hub_we_out),
    .mode_q(u_regs.mode_q)
);

// File: tb/test_dbg_break_ctrl.sv
`timescale 1ns/1ps
module test_dbg_break_ctrl;

    localparam int PC_W = 20, DATA_W = 32, NCORE = 8, HUB_AW = 20;
    localparam logic [31:0] M_STEP = 32'h01, M_ADDR = 32'h02, M_INSN = 32'h04,
                            M_ASYN = 32'h08, M_CNT = 32'h10,
                            M_WMSK = 32'h20, M_WVAL = 32'h40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ret_vld = 0, ret_wr = 0, cfg_we = 0, reti0 = 0;
    logic hub_we_in = 0, prot_en = 0;
    logic [PC_W-1:0] ret_pc = '0;
    logic [DATA_W-1:0] ret_insn = '0, cfg_data = '0;
    logic [NCORE-1:0] async_req = '0;
    logic [2:0] cfg_sel = '0;
    logic [HUB_AW-1:0] hub_addr = '0;
    logic dbg_irq, in_dbg, hub_we_out;
    int checks = 0, failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dbg_break_ctrl i_dbg_break_ctrl (
        .clk(clk), .rst_n(rst_n), .ret_vld(ret_vld), .ret_pc(ret_pc),
        .ret_insn(ret_insn), .ret_wr(ret_wr), .async_req(async_req),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .reti0(reti0), .hub_we_in(hub_we_in), .hub_addr(hub_addr),
        .prot_en(prot_en), .dbg_irq(dbg_irq), .in_dbg(in_dbg),
        .hub_we_out(hub_we_out)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic retire(input logic [PC_W-1:0] pc, input logic [31:0] insn, input logic wr);
        ret_vld = 1; ret_pc = pc; ret_insn = insn; ret_wr = wr;
        tick();
        ret_vld = 0; ret_wr = 0;
    endtask

    task automatic pulse_async(input int idx);
        async_req = '0;
        async_req[idx] = 1'b1;
        tick();
        async_req = '0;
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [31:0] data);
        cfg_we = 1; cfg_sel = sel; cfg_data = data;
        tick();
        cfg_we = 0;
    endtask

    // Write all conditions from inside debug, then return
    task automatic arm(input logic [31:0] mode, input logic [31:0] addr,
                       input logic [31:0] mask, input logic [31:0] cmp,
                       input logic [31:0] cnt);
        cfg(3'd0, mode); cfg(3'd1, addr); cfg(3'd2, mask);
        cfg(3'd3, cmp);  cfg(3'd4, cnt);
        reti0 = 1; tick(); reti0 = 0;
        chk(in_dbg, 0, "R9 in_dbg low after return");
    endtask

    task automatic enter_via_async;
        pulse_async(3);
        chk(dbg_irq, 1, "R6 enter via sibling request");
    endtask

    task automatic t_reset;
        chk(dbg_irq, 0, "R1 reset dbg_irq");
        chk(in_dbg, 0, "R1 reset in_dbg");
        retire('0, 32'h0, 1'b0);
        chk(dbg_irq, 0, "R1 no break at address 0 after reset");
    endtask

    task automatic t_locked;
        cfg(3'd0, M_STEP);
        retire(20'h10, 32'h1, 1'b0);
        chk(dbg_irq, 0, "R8 write outside debug ignored");
    endtask

    task automatic t_async;
        pulse_async(0);
        chk(dbg_irq, 0, "R6 own request ignored");
        pulse_async(1);
        chk(dbg_irq, 1, "R6 sibling request breaks");
        chk(in_dbg, 1, "R10 in_dbg with request");
        tick();
        chk(dbg_irq, 0, "R10 request lasts one cycle");
        reti0 = 1; tick(); reti0 = 0;
        chk(in_dbg, 0, "R9 return leaves debug");
        // async disabled: arm with no async then come back? keep async armed
    endtask

    task automatic t_ignore_and_step;
        enter_via_async();
        reti0 = 1; tick(); reti0 = 0;           // return during entry cycle
        chk(in_dbg, 1, "R9 return in entry cycle ignored");
        pulse_async(2);
        chk(dbg_irq, 0, "R7 request in debug ignored");
        retire(20'h5, 32'h0, 1'b0);
        chk(dbg_irq, 0, "R7 retire in debug ignored");
        arm(M_STEP, 0, 0, 0, 0);
        tick();
        chk(dbg_irq, 0, "R7 no queued request; R2 no retire no break");
        retire(20'h77, 32'h0, 1'b0);
        chk(dbg_irq, 1, "R2 single-step break after one retire");
    endtask

    task automatic t_addr;
        arm(M_ADDR | M_ASYN, 32'h123, 0, 0, 0);
        retire(20'h100, 32'h0, 1'b0);
        chk(dbg_irq, 0, "R3 other address no break");
        retire(20'h123, 32'h0, 1'b0);
        chk(dbg_irq, 1, "R3 address match breaks");
    endtask

    task automatic t_insn;
        tick();
        arm(M_INSN | M_ASYN | M_WMSK | M_WVAL, 0, 32'hFF00_0000, 32'hA500_0000, 0);
        retire(20'h1, 32'hA512_3456, 1'b0);
        chk(dbg_irq, 0, "R4 qualifier mismatch no break");
        retire(20'h2, 32'hA4FF_FFFF, 1'b1);
        chk(dbg_irq, 0, "R4 pattern mismatch no break");
        retire(20'h3, 32'hA5FF_FFFF, 1'b1);
        chk(dbg_irq, 1, "R4 pattern and qualifier match");
    endtask

    task automatic t_count;
        tick();
        arm(M_ADDR | M_CNT | M_ASYN, 32'h40, 0, 0, 3);
        retire(20'h40, 32'h0, 1'b0);
        chk(dbg_irq, 0, "R5 first hit no break");
        retire(20'h41, 32'h0, 1'b0);
        retire(20'h40, 32'h0, 1'b0);
        chk(dbg_irq, 0, "R5 second hit no break");
        retire(20'h40, 32'h0, 1'b0);
        chk(dbg_irq, 1, "R5 third hit breaks");
    endtask

    task automatic t_gate;
        tick();
        hub_we_in = 1; prot_en = 1; hub_addr = 20'hFC000;
        #1 chk(hub_we_out, 1, "R11 debug bypasses protection");
        arm(M_ASYN, 0, 0, 0, 0);
        #1 chk(hub_we_out, 0, "R11 top region blocked");
        hub_addr = 20'hFBFFF;
        #1 chk(hub_we_out, 1, "R11 below top region allowed");
        hub_addr = 20'hFFFFF; prot_en = 0;
        #1 chk(hub_we_out, 1, "R11 switch off allows");
        hub_we_in = 0;
        #1 chk(hub_we_out, 0, "R11 no write no enable");
        @(negedge clk);
    endtask

    task automatic t_async_off;
        enter_via_async();
        tick();
        arm(32'h0, 0, 0, 0, 0);
        pulse_async(4);
        chk(dbg_irq, 0, "R6 disabled request ignored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_locked();
        t_async();
        t_ignore_and_step();
        t_addr();
        t_insn();
        t_count();
        t_gate();
        t_async_off();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule